// File: doc/BRIEF.md
# Full-Scale Gain Calibration Controller

This controller runs the second pass of a capacitance sensor calibration, after the zero-point pass has stored one offset code for each electrode pair. During this pass the sensor is filled with a high-permittivity material. The controller walks the pairs in ascending order. For each pair it first reads that pair's offset code from the offset table and drives it onto the offset DAC. It then looks for the gain setting that brings the ADC reading as close to full scale as possible while keeping it out of saturation.

Two gain stages sit in series. The first is an AC stage with a gain of either 10 or 100. The second is a DC stage with five binary gains. The search starts at the highest combined gain and steps downward one setting at a time. Before each conversion request the controller waits a fixed settling time. The first reading that is not saturated ends the search for that pair. That setting, together with the ADC reading (the residue), is written to the gain table. If every setting saturates, the controller writes the lowest setting and marks the record with an error flag.

Top module: `gcal_fullscale_ctrl`

## Requirements
- R1: While reset is high and after reset: done=0, tbl_wr_en=0, adc_req=0, ac_gain_hi=1 and dc_gain_sel=4. Reset is synchronous and active high.
- R2: At every conversion request for pair p, dac_code equals the word the offset table returned for address p. The table read has one cycle of latency.
- R3: The first conversion of every pair uses the maximum gain: ac_gain_hi=1 (AC gain 100) and dc_gain_sel=4. The DC select codes 0,1,2,3,4 mean gains 1,2,4,8,16.
- R4: After a saturated reading with dc_gain_sel above 0, the next conversion uses a DC code one lower and the same AC gain.
- R5: After a saturated reading with AC gain 100 and DC code 0, the next conversion uses AC gain 10 (ac_gain_hi=0) and DC code 4.
- R6: A reading is saturated when adc_data >= sat_thresh. The first reading that is not saturated ends the search for the pair. A reading equal to the threshold counts as saturated.
- R7: Each pair produces exactly one table write, in ascending pair order, at tbl_wr_addr = pair index. The write data is laid out as bit 16 = error flag, bit 15 = AC gain high, bits 14:12 = DC code, bits 11:0 = residue (the last ADC reading).
- R8: If the reading at AC gain 10 and DC code 0 is still saturated, the record holds error=1, AC low, DC code 0 and that reading as the residue.
- R9: ac_gain_hi, dc_gain_sel and dac_code hold steady for at least SETTLE_CYC cycles before each adc_req pulse.
- R10: done rises after the write for the last pair and stays high until the next start. A start clears done and runs a new pass from pair 0.
- R11: sat_thresh is taken from its input, so a lower threshold selects lower gains for the same readings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration pass (taken while idle) |
| sat_thresh | input | 12 | Saturation threshold code |
| ofs_rd_addr | output | $clog2(NUM_PAIRS) | Offset table read address |
| ofs_rd_data | input | OFS_W | Offset table read data, one cycle after the address |
| dac_code | output | OFS_W | Offset DAC code |
| ac_gain_hi | output | 1 | 1 = AC gain 100, 0 = AC gain 10 |
| dc_gain_sel | output | 3 | DC gain code (0..4 = gain 1..16) |
| adc_req | output | 1 | One-cycle conversion request |
| adc_valid | input | 1 | Conversion result valid |
| adc_data | input | 12 | Conversion result |
| tbl_wr_en | output | 1 | Gain table write strobe |
| tbl_wr_addr | output | $clog2(NUM_PAIRS) | Gain table write address (pair index) |
| tbl_wr_data | output | 17 | {error, AC high, DC code[2:0], residue[11:0]} |
| done | output | 1 | Pass complete |

## Verification
The bench builds the controller with NUM_PAIRS=8 and SETTLE_CYC=3. With these values a full pass, including pairs that walk all ten gain settings, finishes in a few hundred cycles. It also means the last-pair wrap and the settling window can be checked at every conversion. The eight modelled pairs are chosen to hit each ending:
- maximum gain accepted at once,
- a reading exactly at the threshold,
- the drop of the AC stage,
- a reading one code below the threshold at the lowest gain,
- exhaustion with error.

A second pass with a lower threshold moves several of these outcomes.

// File: rtl/gcal_pkg.sv
package gcal_pkg;

    localparam int ADC_W = 12;
    localparam int DC_W  = 3;
    localparam logic [DC_W-1:0] DC_TOP = 3'd4;

    typedef struct packed {
        logic             err;
        logic             ac_hi;
        logic [DC_W-1:0]  dc;
        logic [ADC_W-1:0] residue;
    } gcal_rec_t;

    localparam int REC_W = $bits(gcal_rec_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CAP,
        ST_SETTLE,
        ST_CONV,
        ST_WAIT,
        ST_WRITE
    } gcal_state_t;

    function automatic logic is_sat(input logic [ADC_W-1:0] rd,
                                    input logic [ADC_W-1:0] thr);
        return rd >= thr;
    endfunction

endpackage

// File: rtl/gcal_gain_stepper.sv
module gcal_gain_stepper
    import gcal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    output logic            ac_hi,
    output logic [DC_W-1:0] dc_sel,
    output logic            at_floor
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            ac_hi  <= 1'b1;
            dc_sel <= DC_TOP;
        end else if (step) begin
            if (dc_sel != '0) begin
                dc_sel <= dc_sel - 1'b1;
            end else if (ac_hi) begin
                ac_hi  <= 1'b0;
                dc_sel <= DC_TOP;
            end
        end
    end

    assign at_floor = !ac_hi && (dc_sel == '0);

    // R3
    dc_range_chk: assert property (@(posedge clk) disable iff (rst)
        dc_sel <= DC_TOP);

    // R5
    ac_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ac_hi && dc_sel == '0) |=> (!ac_hi && dc_sel == DC_TOP));

endmodule

// File: rtl/gcal_settle_timer.sv
module gcal_settle_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CW'(CYCLES));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(CYCLES));

endmodule

// File: rtl/gcal_fullscale_ctrl.sv
module gcal_fullscale_ctrl
    import gcal_pkg::*;
#(
    parameter int NUM_PAIRS  = 66,
    parameter int SETTLE_CYC = 500,
    parameter int OFS_W      = 12,
    localparam int AW        = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADC_W-1:0]  sat_thresh,
    output logic [AW-1:0]     ofs_rd_addr,
    input  logic [OFS_W-1:0]  ofs_rd_data,
    output logic [OFS_W-1:0]  dac_code,
    output logic              ac_gain_hi,
    output logic [DC_W-1:0]   dc_gain_sel,
    output logic              adc_req,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_data,
    output logic              tbl_wr_en,
    output logic [AW-1:0]     tbl_wr_addr,
    output logic [REC_W-1:0]  tbl_wr_data,
    output logic              done
);

    localparam logic [AW-1:0] LAST = AW'(NUM_PAIRS - 1);

    gcal_state_t st;
    logic [AW-1:0] pair;
    gcal_rec_t     rec;
    logic          sat, reading, step, finish, at_floor, settled;

    assign sat     = is_sat(adc_data, sat_thresh);
    assign reading = (st == ST_WAIT) && adc_valid;
    assign step    = reading && sat && !at_floor;
    assign finish  = reading && (!sat || at_floor);

    gcal_gain_stepper u_stepper (
        .clk      (clk),
        .rst      (rst),
        .load     (st == ST_CAP),
        .step     (step),
        .ac_hi    (ac_gain_hi),
        .dc_sel   (dc_gain_sel),
        .at_floor (at_floor)
    );

    gcal_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_SETTLE),
        .expired (settled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pair     <= '0;
            dac_code <= '0;
            rec      <= '0;
            done     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    done <= 1'b0;
                    pair <= '0;
                    st   <= ST_LOAD;
                end
                ST_LOAD:   st <= ST_CAP;
                ST_CAP: begin
                    dac_code <= ofs_rd_data;
                    st       <= ST_SETTLE;
                end
                ST_SETTLE: if (settled) st <= ST_CONV;
                ST_CONV:   st <= ST_WAIT;
                ST_WAIT: begin
                    if (finish) begin
                        rec <= '{err: sat, ac_hi: ac_gain_hi,
                                 dc: dc_gain_sel, residue: adc_data};
                        st  <= ST_WRITE;
                    end else if (step) begin
                        st <= ST_SETTLE;
                    end
                end
                ST_WRITE: begin
                    if (pair == LAST) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        pair <= pair + 1'b1;
                        st   <= ST_LOAD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ofs_rd_addr = pair;
    assign adc_req     = (st == ST_CONV);
    assign tbl_wr_en   = (st == ST_WRITE);
    assign tbl_wr_addr = pair;
    assign tbl_wr_data = rec;

    // R9
    req_settled_chk: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> ($stable(ac_gain_hi) && $stable(dc_gain_sel) && $stable(dac_code)));

    // R8
    floor_err_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en && rec.err) |-> (!rec.ac_hi && rec.dc == '0));

    // R6
    below_thr_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en && !rec.err) |-> (rec.residue < sat_thresh));

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |=> !tbl_wr_en);

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(tbl_wr_en) && tbl_wr_addr == LAST));

endmodule

// File: tb/gcal_fullscale_ctrl_bench.sv
module gcal_fullscale_ctrl_bench;

    localparam int NP     = 8;
    localparam int SETTLE = 3;
    localparam int ADC_LAT = 2;
    localparam int AW     = $clog2(NP);

    // base, then per pass: ac, dc, err, residue (pass 0: thr 4000, pass 1: thr 3200)
    localparam int VEC [NP][9] = '{
        '{   2, 1,4,0, 320, 1,4,0, 320},
        '{  20, 1,4,0,3200, 1,3,0,1600},
        '{  25, 1,3,0,2000, 1,3,0,2000},
        '{ 300, 1,0,0,3000, 1,0,0,3000},
        '{ 450, 0,3,0,3600, 0,2,0,1800},
        '{5000, 0,0,1,4095, 0,0,1,4095},
        '{  24, 1,4,0,3840, 1,3,0,1920},
        '{3999, 0,0,0,3999, 0,0,1,3999}
    };

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [11:0] sat_thresh = 12'd4000;
    logic [AW-1:0] ofs_rd_addr;
    logic [11:0] ofs_rd_data;
    logic [11:0] dac_code;
    logic ac_gain_hi;
    logic [2:0] dc_gain_sel;
    logic adc_req;
    logic adc_valid = 0;
    logic [11:0] adc_data = '0;
    logic tbl_wr_en;
    logic [AW-1:0] tbl_wr_addr;
    logic [16:0] tbl_wr_data;
    logic done;

    int total = 0;
    int bad = 0;
    int pass_sel = 0;
    int wr_idx = 0;
    int req_k = 0;

    always #2 clk = ~clk;

    gcal_fullscale_ctrl #(.NUM_PAIRS(NP), .SETTLE_CYC(SETTLE), .OFS_W(12)) u_gcal_fullscale_ctrl (
        .clk(clk), .rst(rst), .start(start), .sat_thresh(sat_thresh),
        .ofs_rd_addr(ofs_rd_addr), .ofs_rd_data(ofs_rd_data), .dac_code(dac_code),
        .ac_gain_hi(ac_gain_hi), .dc_gain_sel(dc_gain_sel), .adc_req(adc_req),
        .adc_valid(adc_valid), .adc_data(adc_data), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data), .done(done)
    );

    function automatic int ofs_of(input int p);
        return (p * 37 + 5) & 12'hFFF;
    endfunction

    function automatic int reading(input int base, input logic ac, input int dc);
        int v;
        v = base * (ac ? 10 : 1) * (1 << dc);
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offset table model: one cycle read latency
    always_ff @(posedge clk) ofs_rd_data <= 12'(ofs_of(int'(ofs_rd_addr)));

    // ADC model
    initial begin
        forever begin
            @(negedge clk);
            if (adc_req) begin
                int v;
                v = reading(VEC[int'(ofs_rd_addr)][0], ac_gain_hi, int'(dc_gain_sel));
                repeat (ADC_LAT - 1) @(negedge clk);
                adc_data  = 12'(v);
                adc_valid = 1'b1;
                @(negedge clk);
                adc_valid = 1'b0;
            end
        end
    end

    // monitor
    initial begin
        int stab;
        logic [15:0] prev;
        stab = 0;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                stab = 0;
            end else begin
                if ({ac_gain_hi, dc_gain_sel, dac_code} != prev) stab = 0;
                else stab++;
            end
            prev = {ac_gain_hi, dc_gain_sel, dac_code};
            if (!rst && adc_req) begin
                int e_ac, e_dc;
                e_ac = (req_k < 5) ? 1 : 0;
                e_dc = (req_k < 5) ? 4 - req_k : 9 - req_k;
                if (req_k == 0) begin
                    chk(ac_gain_hi == 1 && dc_gain_sel == 4, "R3 first gain",
                        {ac_gain_hi, dc_gain_sel}, 12);
                end else if (req_k == 5) begin
                    chk(ac_gain_hi == 0 && dc_gain_sel == 4, "R5 ac drop",
                        {ac_gain_hi, dc_gain_sel}, 4);
                end else begin
                    chk(int'(ac_gain_hi) == e_ac && int'(dc_gain_sel) == e_dc, "R4 dc step",
                        {ac_gain_hi, dc_gain_sel}, e_ac * 8 + e_dc);
                end
                chk(int'(ofs_rd_addr) == wr_idx, "R7 pair order", int'(ofs_rd_addr), wr_idx);
                chk(int'(dac_code) == ofs_of(wr_idx), "R2 offset reload", int'(dac_code), ofs_of(wr_idx));
                chk(stab >= SETTLE, "R9 settle", stab, SETTLE);
                req_k++;
            end
            if (!rst && tbl_wr_en) begin
                int b, e_ac, e_dc, e_err, e_res, e_cnt;
                b = 1 + pass_sel * 4;
                e_ac  = VEC[wr_idx][b];
                e_dc  = VEC[wr_idx][b+1];
                e_err = VEC[wr_idx][b+2];
                e_res = VEC[wr_idx][b+3];
                e_cnt = e_err ? 10 : ((e_ac ? 0 : 5) + (4 - e_dc) + 1);
                chk(int'(tbl_wr_addr) == wr_idx, "R7 write addr", int'(tbl_wr_addr), wr_idx);
                chk(int'(tbl_wr_data[15]) == e_ac && int'(tbl_wr_data[14:12]) == e_dc,
                    pass_sel ? "R11 gain fields" : "R6 gain fields",
                    int'(tbl_wr_data[15:12]), e_ac * 8 + e_dc);
                chk(int'(tbl_wr_data[11:0]) == e_res, "R7 residue", int'(tbl_wr_data[11:0]), e_res);
                chk(int'(tbl_wr_data[16]) == e_err, "R8 error flag", int'(tbl_wr_data[16]), e_err);
                chk(req_k == e_cnt, "R6 conversions per pair", req_k, e_cnt);
                wr_idx++;
                req_k = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_pass(input int sel, input logic [11:0] thr);
        pass_sel   = sel;
        sat_thresh = thr;
        wr_idx     = 0;
        req_k      = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R10 done cleared", done, 0);
        while (!done) @(negedge clk);
        chk(wr_idx == NP, "R7 write count", wr_idx, NP);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(done == 0 && tbl_wr_en == 0 && adc_req == 0, "R1 in reset",
            {done, tbl_wr_en, adc_req}, 0);
        chk(ac_gain_hi == 1 && dc_gain_sel == 4, "R1 gains in reset",
            {ac_gain_hi, dc_gain_sel}, 12);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 0 && tbl_wr_en == 0 && adc_req == 0, "R1 after reset",
            {done, tbl_wr_en, adc_req}, 0);

        run_pass(0, 12'd4000);
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R10 done held", done, 1);

        run_pass(1, 12'd3200);
        chk(done == 1'b1, "R10 done after pass two", done, 1);

        // reset in the middle of a pass
        pass_sel   = 0;
        sat_thresh = 12'd4000;
        wr_idx     = 0;
        req_k      = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(done == 0 && tbl_wr_en == 0 && adc_req == 0, "R1 mid-pass reset",
            {done, tbl_wr_en, adc_req}, 0);
        chk(ac_gain_hi == 1 && dc_gain_sel == 4, "R1 gains mid-pass reset",
            {ac_gain_hi, dc_gain_sel}, 12);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(tbl_wr_en == 0 && adc_req == 0, "R1 idle after reset",
            {tbl_wr_en, adc_req}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule